// File: doc/BRIEF.md
# Throttled Counter-Sequence Stream Checker

This block is the receiving end of a link soak test. It accepts words from a valid/ready stream and checks that the payload forms an unbroken run of incrementing counter values. It also limits how fast it takes words. A free-running phase counter decides which cycles may accept a word, so the checker can consume at the full clock rate, at one half or at one quarter. The reduced rates push backpressure into the link under test on purpose.

The first word accepted after reset sets the starting point of the sequence. Each later word must equal the previous word plus one, with wrap-around at the data width. When a word breaks the run, the error flag is set and stays set, the error count goes up by one, and the sequence restarts from the word just received. A 32-bit count of accepted words lets software-free logic or a debugger work out the throughput.

Top module: `stream_chk`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `err_flag` is 0, `word_count` is 0 and `err_count` is 0.
- R2: With `rate_sel` = 0, `in_ready` is high on every cycle.
- R3: With `rate_sel` = 1, `in_ready` is high on exactly half of any 16 consecutive cycles, and never on two cycles in a row.
- R4: With `rate_sel` = 2 or 3, `in_ready` is high on exactly 4 of any 16 consecutive cycles, and never on two cycles in a row.
- R5: A word is accepted only on a clock edge where both `in_valid` and `in_ready` are high. `word_count` rises by one on the cycle after each accepted word. A valid word presented while `in_ready` is low changes no output.
- R6: The first word accepted after reset is never counted as an error, whatever its value.
- R7: An accepted word equal to the previous accepted word plus one, modulo 2^DATA_W (so all-ones followed by zero is included), leaves `err_flag` and `err_count` unchanged.
- R8: An accepted word that differs from the previous word plus one raises `err_count` by one and sets `err_flag` on the next cycle. `err_flag` then stays high until reset. A repeated word counts as such a mismatch.
- R9: After a mismatch, the next expected value is the mismatching word plus one.
- R10: `err_count` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | RATE_W | Consumption rate: 0 full, 1 half, 2 or 3 quarter |
| in_valid | input | 1 | Stream word valid |
| in_data | input | DATA_W | Stream payload |
| in_ready | output | 1 | Checker can take a word this cycle |
| err_flag | output | 1 | Sticky sequence error |
| word_count | output | CNT_W | Number of accepted words |
| err_count | output | ERR_W | Number of mismatches, saturating |

## Verification
The rate gate is measured over 16-cycle windows at each rate setting, with the input idle. The window counts separate the half rate from the quarter rate, and the count of adjacent ready cycles separates a spaced gate from a bursty one. The sequence check is driven with several patterns:
- a clean run across three rates, with idle gaps and valid words held while `in_ready` is low;
- a run that crosses the all-ones to zero wrap;
- a repeated word and a skipped word, followed by their correct successors, which shows whether the checker resynchronises or keeps flagging;
- a long series of mismatches that drives the error count into saturation.

A reset in the middle of the run, followed by an arbitrary seed word, shows that the sequence restarts from the new seed.

// File: rtl/stream_chk_pkg.sv
// Shared constants for the throttled stream checker.
// Assumes rate codes are small unsigned numbers giving log2 of the divisor.
package stream_chk_pkg;
    localparam int unsigned RATE_FULL    = 0;
    localparam int unsigned RATE_HALF    = 1;
    localparam int unsigned RATE_QUARTER = 2;

    // Number of distinct accepting phases per period for a given code.
    function automatic int unsigned accepts_per_period(input int unsigned code,
                                                       input int unsigned max_log2);
        int unsigned s;
        s = (code > max_log2) ? max_log2 : code;
        return (1 << max_log2) >> s;
    endfunction
endpackage

// File: rtl/stream_chk_throttle.sv
// Rate gate: a free-running phase counter opens the ready window once every
// 2^rate_sel cycles, capped at 2^MAX_LOG2. Assumes MAX_LOG2 >= 1.
// ready_o is combinational from the phase register and rate_sel.
module stream_chk_throttle #(
    parameter int unsigned RATE_W   = 2,
    parameter int unsigned MAX_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              ready_o
);
    import stream_chk_pkg::*;

    localparam int unsigned PH_W = MAX_LOG2;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] mask;

    // Advance the phase counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + PH_W'(1);
    end

    // Select the low phase bits that must all be one for acceptance.
    always_comb begin
        for (int i = 0; i < int'(PH_W); i++) begin
            mask[i] = (int'(rate_sel) > i);
        end
        ready_o = &(phase | ~mask);
    end

    // R3
    // half_rate_gap_chk
    half_rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rate_sel) == RATE_HALF && ready_o) |=> (int'(rate_sel) != RATE_HALF || !ready_o))
        else $error("half rate ready on consecutive cycles");

    // R4
    quarter_rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rate_sel) >= RATE_QUARTER && ready_o) |=> (int'(rate_sel) < RATE_QUARTER || !ready_o))
        else $error("quarter rate ready on consecutive cycles");
endmodule

// File: rtl/stream_chk_seq.sv
// Sequence tracker: holds the expected next payload. The first accepted word
// after reset seeds it; every later accepted word is compared and the expected
// value becomes that word plus one, which also resynchronises after a mismatch.
module stream_chk_seq #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              mismatch_o
);
    logic              seeded;
    logic [DATA_W-1:0] expect_q;

    // Flag a compare failure only once a reference exists.
    always_comb begin
        mismatch_o = accept_i && seeded && (data_i != expect_q);
    end

    // Seed on the first word, then track the received word plus one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeded   <= 1'b0;
            expect_q <= '0;
        end else if (accept_i) begin
            seeded   <= 1'b1;
            expect_q <= data_i + DATA_W'(1);
        end
    end

    // R9
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (!accept_i || !seeded || mismatch_o == (data_i != $past(data_i) + DATA_W'(1))))
        else $error("expected value not resynchronised to previous word plus one");
endmodule

// File: rtl/stream_chk_tally.sv
// Counters: accepted words (wrapping), mismatches (saturating) and the sticky
// error flag. Assumes accept_i and mismatch_i come from the same cycle.
module stream_chk_tally #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             mismatch_i,
    output logic [CNT_W-1:0] word_count_o,
    output logic [ERR_W-1:0] err_count_o,
    output logic             err_flag_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    // Count every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_count_o <= '0;
        else if (accept_i) word_count_o <= word_count_o + CNT_W'(1);
    end

    // Count mismatches up to the all-ones ceiling and latch the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count_o <= '0;
            err_flag_o  <= 1'b0;
        end else if (mismatch_i) begin
            err_flag_o <= 1'b1;
            if (err_count_o != ERR_MAX) err_count_o <= err_count_o + ERR_W'(1);
        end
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(word_count_o))
        else $error("word count moved without acceptance");

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |=> err_flag_o)
        else $error("error flag cleared without reset");

    // R8
    mismatch_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_i |=> (err_flag_o && err_count_o != '0))
        else $error("mismatch not recorded");

    // R7
    quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mismatch_i |=> $stable(err_count_o))
        else $error("error count moved without mismatch");

    // R10
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count_o == ERR_MAX) |=> (err_count_o == ERR_MAX))
        else $error("error count wrapped");
endmodule

// File: rtl/stream_chk.sv
// Top: throttled consumer that checks an incrementing counter payload.
// Assumes in_data is meaningful whenever in_valid is high; rate_sel may change
// at any cycle and takes effect immediately on in_ready.
module stream_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned ERR_W    = 16,
    parameter int unsigned RATE_W   = 2,
    parameter int unsigned MAX_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              err_flag,
    output logic [CNT_W-1:0]  word_count,
    output logic [ERR_W-1:0]  err_count
);
    logic accept;
    logic mismatch;

    // Handshake completes when the source offers and the gate is open.
    always_comb begin
        accept = in_valid && in_ready;
    end

    stream_chk_throttle #(.RATE_W(RATE_W), .MAX_LOG2(MAX_LOG2)) u_throttle (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .ready_o  (in_ready)
    );

    stream_chk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .data_i     (in_data),
        .mismatch_o (mismatch)
    );

    stream_chk_tally #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_tally (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .mismatch_i   (mismatch),
        .word_count_o (word_count),
        .err_count_o  (err_count),
        .err_flag_o   (err_flag)
    );

    // R2
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> in_ready)
        else $error("full rate gate closed");

    // R6
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '0) |-> !mismatch)
        else $error("first word flagged");
endmodule

// File: tb/stream_chk_tb.sv
module stream_chk_tb;
    localparam int unsigned PERIOD = 10;
    localparam int unsigned DW     = 16;
    localparam int unsigned EW     = 4;

    typedef struct packed {
        logic [31:0]   words;
        logic [EW-1:0] errs;
        logic          flag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          err_flag;
    logic [31:0]   word_count;
    logic [EW-1:0] err_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    exp_t          sb[$];
    bit            m_seeded;
    logic [DW-1:0] m_exp;
    logic [31:0]   m_words;
    logic [EW-1:0] m_errs;
    logic          m_flag;

    stream_chk #(.DATA_W(DW), .CNT_W(32), .ERR_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .err_flag(err_flag),
        .word_count(word_count), .err_count(err_count)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        m_seeded = 0; m_exp = '0; m_words = '0; m_errs = '0; m_flag = 0;
        sb.delete();
    endtask

    // Reset for three cycles, release at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
        check(word_count == 0, "R1 word_count", word_count, 0);
        check(err_count == 0, "R1 err_count", err_count, 0);
    endtask

    // Driver: offer one word, hold it until accepted, push the expected outputs.
    task automatic send(input logic [DW-1:0] d);
        exp_t e;
        in_valid = 1'b1; in_data = d;
        #1;
        while (!in_ready) begin
            @(posedge clk); #2;
            check(word_count == m_words, "R5 held word ignored", word_count, m_words);
            @(negedge clk); #1;
        end
        if (!m_seeded) begin
            m_seeded = 1; m_exp = d + 1'b1;
        end else if (d != m_exp) begin
            if (m_errs != '1) m_errs = m_errs + 1'b1;
            m_flag = 1; m_exp = d + 1'b1;
        end else begin
            m_exp = m_exp + 1'b1;
        end
        m_words = m_words + 1;
        e.words = m_words; e.errs = m_errs; e.flag = m_flag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Count ready cycles and adjacent ready pairs in a 16-cycle window.
    task automatic measure(input logic [1:0] r, input int exp_hi, input int exp_pairs, input string tag);
        int hi = 0;
        int pairs = 0;
        bit prev = 0;
        in_valid = 1'b0; rate_sel = r;
        for (int k = 0; k < 16; k++) begin
            #1;
            if (in_ready) hi++;
            if (in_ready && prev && k > 0) pairs++;
            prev = in_ready;
            @(negedge clk);
        end
        check(hi == exp_hi, {tag, " ready count"}, hi, exp_hi);
        check(pairs == exp_pairs, {tag, " adjacent ready"}, pairs, exp_pairs);
    endtask

    // Monitor: compare outputs one cycle after each accepted word (R5, R8).
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(word_count == e.words, "R5 word_count", word_count, e.words);
                check(err_count == e.errs, "R8 err_count", err_count, e.errs);
                check(err_flag == e.flag, "R8 err_flag", err_flag, e.flag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        #1 check(in_ready == 1'b1, "R2 ready after reset", in_ready, 1);
        @(negedge clk);

        measure(2'd0, 16, 15, "R2");
        measure(2'd1, 8, 0, "R3");
        measure(2'd2, 4, 0, "R4");
        measure(2'd3, 4, 0, "R4 code3");

        // R6 arbitrary seed, R7 clean run across rates
        rate_sel = 2'd0;
        for (int k = 0; k < 10; k++) send(DW'(100 + k));
        rate_sel = 2'd1;
        for (int k = 10; k < 20; k++) send(DW'(100 + k));
        rate_sel = 2'd2;
        for (int k = 20; k < 26; k++) begin send(DW'(100 + k)); idle(k % 3); end
        idle(2);
        check(err_count == 0 && err_flag == 0, "R7 clean run", err_count, 0);

        // R8 mismatch into wrap region, R7 wrap, R9 resync
        rate_sel = 2'd0;
        send(16'hFFFD); send(16'hFFFE); send(16'hFFFF); send(16'h0000); send(16'h0001);
        idle(2);
        check(err_count == 1, "R9 resync after jump", err_count, 1);
        check(err_count == 1, "R7 wrap no error", err_count, 1);

        // R8 repeated word, then R9 correct successor
        send(16'h0001); send(16'h0002);
        idle(2);
        check(err_count == 2, "R8 repeat flagged", err_count, 2);

        // R8 skipped word, R9 successor
        rate_sel = 2'd1;
        send(16'h0005); send(16'h0006);
        idle(2);
        check(err_count == 3 && err_flag, "R9 skip resync", err_count, 3);

        // R10 saturation
        rate_sel = 2'd0;
        for (int k = 0; k < 17; k++) send(m_exp + 16'd3);
        idle(2);
        check(err_count == 4'hF, "R10 saturated", err_count, 15);
        check(err_flag == 1'b1, "R8 sticky flag", err_flag, 1);
        idle(3);
        check(err_flag == 1'b1, "R8 flag still set", err_flag, 1);

        // R1 and R6 after a mid-run reset
        do_reset();
        send(16'd500); send(16'd501);
        idle(2);
        check(err_count == 0 && word_count == 2, "R6 new seed", err_count, 0);

        idle(2);
        finish_run();
    end
endmodule